// File: doc/BRIEF.md
# Receive Flow-Control Credit Tracker

This block keeps a running count of the empty receive buffers that software has handed to a DMA receive engine. There is one count for each pair of DMA channels. Each count is compared against a programmable low mark and high mark, and the block drives a per-unit pause request toward the traffic source. Pause turns on when the supply of buffers runs short. It turns off only after software has refilled the supply past the high mark. This hysteresis stops the pause line from toggling on every buffer.

Software reaches the block through a simple word-addressed write port. A configuration word holds a global enable in bit 0 and one enable per unit above it. Each unit has three words: the low mark, the high mark, and a credit word. Writing the credit word adds its low bits to the count, and its top bit selects a force override that keeps pause off. The DMA engine pulses a consume input with a channel number each time it fills a buffer. Typical use: software sets the low mark to a third of the ring size and the high mark to two thirds, then writes 1 to the credit word each time it recycles a buffer.

Top module: `rxfc_credit_bank`

## Requirements
- R1: Writes are word-addressed by byte offset. Offset 0x00 is the configuration word: bit 0 is the global enable and bit n+1 enables unit n. Unit n has its low mark at 0x04+12n, its high mark at 0x08+12n and its credit word at 0x0C+12n. A write to any other offset changes nothing.
- R2: A consume pulse for channel c affects only unit c>>1, so channels 2n and 2n+1 share unit n.
- R3: A credit-word write adds its bits [CNT_W-1:0] to the unit's count. The count saturates at 2^CNT_W-1.
- R4: Each consume pulse takes one from the count and stops at zero. A credit write and a consume pulse in the same cycle both apply, giving the net result.
- R5: Pause turns on when the updated count is below the low mark.
- R6: Once on, pause stays on until the updated count is at or above the high mark. Between the two marks, pause keeps its previous value. If the count is below the low mark, pause is on even when the count also meets the high mark.
- R7: Bit 31 of a credit write loads the force flag, and every credit write reloads it. While the flag is set, pause is off.
- R8: A unit is active only when both the global bit and its own bit are set. An inactive unit holds its count at zero, keeps pause off, and ignores credit writes and consume pulses.
- R9: After reset, configuration, marks, counts, force flags and pause are all zero.
- R10: Pause is registered. It reflects a credit write or consume pulse after the next clock edge. Writes to the configuration word or to a mark take effect from the edge after the one that stores them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| consume_valid | input | 1 | One buffer consumed this cycle |
| consume_chan | input | CHAN_W | Channel that consumed the buffer |
| pause_o | output | NUM_CHANS/2 | Per-unit pause request |

## Verification
The count is internal, so a wrong count shows only through pause. A mis-added or wrapped count appears as pause flipping, or failing to flip, when the low or high mark is crossed. The bench therefore drives counts across both marks and across both saturation limits, and it samples pause one edge after each stimulus. A count that wraps instead of saturating shows up right after the next refill, as pause that should have released but stays on. A consume pulse routed to the wrong unit, or a credit write that lands during disable, shows up on the next mark crossing of the affected unit.

// File: rtl/rxfc_pkg.sv
`timescale 1ns/1ps
package rxfc_pkg;

  localparam int unsigned FC_FIRST_OFS = 4;
  localparam int unsigned FC_STRIDE    = 12;
  localparam int unsigned FC_WORD      = 4;

  typedef enum logic [1:0] {
    FC_LO    = 2'd0,
    FC_HI    = 2'd1,
    FC_ALLOC = 2'd2
  } fc_reg_e;

  typedef struct packed {
    logic lo;
    logic hi;
    logic alloc;
  } fc_wr_t;

  function automatic int unsigned fc_reg_ofs(int unsigned unit, fc_reg_e kind);
    return FC_FIRST_OFS + FC_STRIDE * unit + FC_WORD * int'(kind);
  endfunction

endpackage

// File: rtl/rxfc_wr_decode.sv
`timescale 1ns/1ps
module rxfc_wr_decode
  import rxfc_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  output logic                          cfg_we,
  output fc_wr_t [NUM_UNITS-1:0]        unit_we
);

  assign cfg_we = wr_en && (wr_addr == '0);

  for (genvar n = 0; n < NUM_UNITS; n++) begin : g_unit
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(fc_reg_ofs(n, FC_LO));
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(fc_reg_ofs(n, FC_HI));
    localparam logic [ADDR_W-1:0] A_AL = ADDR_W'(fc_reg_ofs(n, FC_ALLOC));
    assign unit_we[n].lo    = wr_en && (wr_addr == A_LO);
    assign unit_we[n].hi    = wr_en && (wr_addr == A_HI);
    assign unit_we[n].alloc = wr_en && (wr_addr == A_AL);
  end

endmodule

// File: rtl/rxfc_consume_route.sv
`timescale 1ns/1ps
module rxfc_consume_route #(
  parameter int NUM_UNITS = 8,
  parameter int CHAN_W    = 4
) (
  input  logic                 consume_valid,
  input  logic [CHAN_W-1:0]    consume_chan,
  output logic [NUM_UNITS-1:0] unit_hit
);

  logic [CHAN_W-1:0] pair_idx;
  assign pair_idx = consume_chan >> 1;

  for (genvar n = 0; n < NUM_UNITS; n++) begin : g_hit
    assign unit_hit[n] = consume_valid && (pair_idx == CHAN_W'(n));
  end

endmodule

// File: rtl/rxfc_unit.sv
`timescale 1ns/1ps
module rxfc_unit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic             alloc_we,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_force,
  input  logic             consume_i,
  output logic             pause_o
);

  localparam int WW = CNT_W + 2;
  localparam logic [WW-1:0] MAXV = {2'b00, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] credit_q, credit_n;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic             force_q, force_n;
  logic             pause_q, pause_n;
  logic [WW-1:0]    wsum;

  always_comb begin
    wsum = {2'b00, credit_q} + (alloc_we ? {2'b00, wr_cnt} : '0);
    if (consume_i) begin
      wsum = (wsum == '0) ? '0 : wsum - 1'b1;
    end
    credit_n = (wsum > MAXV) ? {CNT_W{1'b1}} : wsum[CNT_W-1:0];
    if (!active_i) begin
      credit_n = '0;
    end
  end

  assign force_n = alloc_we ? wr_force : force_q;

  always_comb begin
    pause_n = pause_q;
    if (!active_i || force_n) begin
      pause_n = 1'b0;
    end else if (credit_n < lo_q) begin
      pause_n = 1'b1;
    end else if (credit_n >= hi_q) begin
      pause_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      force_q  <= 1'b0;
      pause_q  <= 1'b0;
    end else begin
      credit_q <= credit_n;
      force_q  <= force_n;
      pause_q  <= pause_n;
      if (lo_we) lo_q <= wr_cnt;
      if (hi_we) hi_q <= wr_cnt;
    end
  end

  assign pause_o = pause_q;

  // R8: inactive unit is empty and quiet
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (credit_q == '0) && !pause_q);

  // R7: force keeps pause off
  p_force_release_r7: assert property (@(posedge clk) disable iff (rst)
    force_q |-> !pause_q);

  // R5: pause only rises below the low mark
  p_pause_below_lo_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pause_q) |-> (credit_q < $past(lo_q)));

  // R6: an active unit releases pause only at or above the high mark, or under force
  p_release_at_hi_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(pause_q) && $past(active_i)) |-> ((credit_q >= $past(hi_q)) || force_q));

  // R4: the count stops at zero
  p_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (active_i && consume_i && !alloc_we && credit_q == '0) |=> (credit_q == '0));

  // R3: the count stops at its maximum
  p_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
    (active_i && alloc_we && !consume_i && credit_q == {CNT_W{1'b1}}) |=>
    (credit_q == {CNT_W{1'b1}}));

endmodule

// File: rtl/rxfc_credit_bank.sv
`timescale 1ns/1ps
module rxfc_credit_bank
  import rxfc_pkg::*;
#(
  parameter int NUM_CHANS = 16,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int CHAN_W    = $clog2(NUM_CHANS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  input  logic                     consume_valid,
  input  logic [CHAN_W-1:0]        consume_chan,
  output logic [NUM_CHANS/2-1:0]   pause_o
);

  localparam int NUM_UNITS = NUM_CHANS / 2;
  localparam int CFG_W     = NUM_UNITS + 1;
  localparam int FORCE_BIT = 31;

  logic                   cfg_we;
  fc_wr_t [NUM_UNITS-1:0] unit_we;
  logic [NUM_UNITS-1:0]   unit_hit;
  logic [CFG_W-1:0]       cfg_q;
  logic                   unused_bits;

  assign unused_bits = ^wr_data;

  rxfc_wr_decode #(
    .NUM_UNITS (NUM_UNITS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cfg_we  (cfg_we),
    .unit_we (unit_we)
  );

  rxfc_consume_route #(
    .NUM_UNITS (NUM_UNITS),
    .CHAN_W    (CHAN_W)
  ) u_route (
    .consume_valid (consume_valid),
    .consume_chan  (consume_chan),
    .unit_hit      (unit_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= wr_data[CFG_W-1:0];
    end
  end

  for (genvar n = 0; n < NUM_UNITS; n++) begin : g_unit
    rxfc_unit #(
      .CNT_W (CNT_W)
    ) u_unit (
      .clk       (clk),
      .rst       (rst),
      .active_i  (cfg_q[0] && cfg_q[n+1]),
      .lo_we     (unit_we[n].lo),
      .hi_we     (unit_we[n].hi),
      .alloc_we  (unit_we[n].alloc),
      .wr_cnt    (wr_data[CNT_W-1:0]),
      .wr_force  (wr_data[FORCE_BIT]),
      .consume_i (unit_hit[n]),
      .pause_o   (pause_o[n])
    );
  end

  // R1: configuration word loads from a write at offset zero
  p_cfg_load_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> (cfg_q == $past(wr_data[CFG_W-1:0])));

  // R1: one write reaches at most one register
  p_single_target_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_we, unit_we}));

  // R2: a consume pulse reaches at most one unit
  p_route_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_hit));

  // R9: pause is clear right after reset
  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pause_o == '0));

endmodule

// File: tb/sim_rxfc_credit_bank.sv
`timescale 1ns/1ps
module sim_rxfc_credit_bank;

  localparam int NC = 16;
  localparam int NU = NC / 2;
  localparam int CW = 8;
  localparam int AW = 8;
  localparam int CHW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          consume_valid = 1'b0;
  logic [CHW-1:0] consume_chan = '0;
  logic [NU-1:0] pause_o;

  always #10 clk = ~clk;

  rxfc_credit_bank #(.NUM_CHANS(NC), .CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .consume_valid(consume_valid), .consume_chan(consume_chan), .pause_o(pause_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model, built from the requirements
  int        m_cr[NU];
  int        m_lo[NU];
  int        m_hi[NU];
  bit        m_fr[NU];
  bit        m_pz[NU];
  bit [NU:0] m_cfg;

  logic [NU-1:0] exp_q[$];
  string         tag_q[$];

  function automatic int lo_a(int n); return 4 + 12 * n; endfunction
  function automatic int hi_a(int n); return 8 + 12 * n; endfunction
  function automatic int al_a(int n); return 12 + 12 * n; endfunction

  task automatic model_edge(bit we, int addr, logic [31:0] d, bit cv, int ch);
    logic [NU-1:0] ev;
    for (int n = 0; n < NU; n++) begin
      bit act, al, cs, fn;
      int cn;
      act = m_cfg[0] && m_cfg[n+1];
      al  = we && addr == al_a(n);
      cs  = cv && (ch >> 1) == n;
      fn  = al ? d[31] : m_fr[n];
      if (!act) cn = 0;
      else begin
        cn = m_cr[n] + (al ? int'(d[CW-1:0]) : 0) - (cs ? 1 : 0);
        if (cn < 0) cn = 0;
        if (cn > CMAX) cn = CMAX;
      end
      if (!act || fn) m_pz[n] = 0;
      else if (cn < m_lo[n]) m_pz[n] = 1;
      else if (cn >= m_hi[n]) m_pz[n] = 0;
      m_cr[n] = cn;
      m_fr[n] = fn;
      if (we && addr == lo_a(n)) m_lo[n] = int'(d[CW-1:0]);
      if (we && addr == hi_a(n)) m_hi[n] = int'(d[CW-1:0]);
      ev[n] = m_pz[n];
    end
    if (we && addr == 0) m_cfg = d[NU:0];
    exp_q.push_back(ev);
  endtask

  task automatic step(bit we, int addr, logic [31:0] d, bit cv, int ch, string tag);
    wr_en = we; wr_addr = AW'(addr); wr_data = d;
    consume_valid = cv; consume_chan = CHW'(ch);
    @(posedge clk);
    model_edge(we, addr, d, cv, ch);
    tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; consume_valid = 1'b0;
  endtask

  task automatic wr(int addr, logic [31:0] d, string tag); step(1, addr, d, 0, 0, tag); endtask
  task automatic cons(int ch, string tag); step(0, 0, 32'h0, 1, ch, tag); endtask
  task automatic idle(string tag); step(0, 0, 32'h0, 0, 0, tag); endtask

  // monitor: compares each expected item one edge after its stimulus
  always @(negedge clk) begin
    if (exp_q.size() > 0 && tag_q.size() > 0) begin
      logic [NU-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (pause_o !== e) begin
        n_fail++;
        $display("FAIL %s pause_o=%b expected=%b", t, pause_o, e);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NU; n++) begin
      m_cr[n] = 0; m_lo[n] = 0; m_hi[n] = 0; m_fr[n] = 0; m_pz[n] = 0;
    end
    m_cfg = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    n_checks++;
    if (pause_o !== '0) begin
      n_fail++;
      $display("FAIL R9 pause_o=%b expected=%b", pause_o, {NU{1'b0}});
    end
    idle("R9");

    wr(0, 32'h3, "R1");
    wr(lo_a(0), 2, "R1");
    wr(hi_a(0), 4, "R1");
    idle("R5");
    wr(al_a(0), 1, "R6");
    wr(al_a(0), 2, "R6");
    wr(al_a(0), 1, "R10");
    cons(0, "R4");
    cons(1, "R2");
    cons(0, "R5");
    step(1, al_a(0), 3, 1, 0, "R4");
    wr(al_a(0), 2, "R6");
    for (int i = 0; i < 7; i++) cons(0, "R4");
    wr(al_a(0), 4, "R4");
    for (int i = 0; i < 4; i++) cons(0, "R5");
    wr(al_a(0), 32'h8000_0000, "R7");
    cons(0, "R7");
    wr(al_a(0), 0, "R7");
    idle("R7");

    wr(hi_a(0), CMAX, "R3");
    idle("R3");
    wr(al_a(0), 200, "R3");
    wr(al_a(0), 200, "R3");
    idle("R3");

    wr(0, 32'h1, "R8");
    wr(al_a(0), 5, "R8");
    cons(0, "R8");
    wr(0, 32'h3, "R8");
    idle("R8");
    idle("R8");
    wr(0, 32'h2, "R8");
    wr(al_a(0), 5, "R8");
    wr(0, 32'h3, "R8");
    idle("R8");
    idle("R8");

    wr(0, 32'h3 | (32'h1 << 4), "R2");
    wr(lo_a(3), 1, "R2");
    wr(hi_a(3), 2, "R2");
    idle("R2");
    cons(6, "R2");
    wr(al_a(3), 2, "R2");
    cons(7, "R2");
    cons(6, "R2");
    wr(al_a(0), 3, "R2");
    cons(1, "R2");

    wr(8'hF0, 32'hFF, "R1");
    wr(8'h0E, 32'hFF, "R1");
    idle("R1");
    wr(lo_a(3), 0, "R1");
    idle("R1");
    idle("R1");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule